// File: doc/BRIEF.md
# Two-Level Address Translation Buffer with Address-Space Tags

This block translates virtual addresses to physical page numbers through two fully associative tables. A small instruction table serves instruction fetches. A larger unified table serves data accesses and acts as the backing store for the instruction table. Each entry carries a page number, a physical page number, an address-space tag, a valid flag and a shared flag. Pages are 1 KB, so the page number is the virtual address from bit 10 upward.

A lookup request gives the address, an instruction/data flag, the privileged-mode bit and the single-virtual-space control bit. The current address-space tag is the low 8 bits of the page-table-entry high input. The result appears one cycle later as one of four outcomes: hit with a physical page number, instruction miss, data miss, or multiple-hit error.

An instruction fetch that misses the instruction table searches the unified table in the same cycle. If that search finds a single match, the entry is copied into the instruction table at its round-robin slot and the fetch completes as a hit. Software fills the unified table with a load command. The command writes the slot named by an internal replacement counter, taking the page number and tag from the high input and the physical page, valid flag and shared flag from the low input. The counter then advances.

Top module: `tlb_two_level`

## Requirements
- R1: After reset no entry is valid, all outcome outputs are 0, and every lookup misses.
- R2: `resp_valid_o` is 1 exactly in the cycle after a cycle with `req_i` high. When it is 1, exactly one of `hit_o`, `itlb_miss_o`, `dtlb_miss_o` and `multi_hit_o` is 1. When it is 0, all four are 0.
- R3: An entry loaded with valid bit `pte_lo_i[8]`=0 never matches.
- R4: Tag comparison is enabled when `single_virt_i`=0 or `priv_i`=0. When it is enabled, an entry matches only if its stored tag equals `pte_hi_i[7:0]`. When both bits are 1, the tag is ignored.
- R5: The shared bit `pte_lo_i[1]` has no effect on matching. A shared entry with a different tag misses while tag comparison is enabled.
- R6: Matching compares `va_i[31:10]` with the stored page number and ignores `va_i[9:0]`.
- R7: The load command writes unified slot `urc`. The page number comes from `pte_hi_i[31:10]`, the tag from `pte_hi_i[7:0]` and the physical page from `pte_lo_i[28:10]`. Afterwards `urc` increments modulo 64, starting from 0 at reset. The 65th load overwrites the slot written by the 1st load.
- R8: A data lookup searches only the unified table. When no entry matches, it reports `dtlb_miss_o`.
- R9: An instruction lookup searches the instruction table first. If that misses and the unified table has one match, the entry is copied into the instruction table and the lookup returns a hit with that entry's physical page. Later fetches to that page are served from the copy.
- R10: An instruction lookup that misses both tables reports `itlb_miss_o`, never `dtlb_miss_o`.
- R11: If more than one valid entry of the table being decided matches, the outcome is `multi_hit_o` and there is no hit.
- R12: Instruction-table refills go to slots 0,1,2,3,0,... in order, starting from slot 0 at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Lookup request |
| va_i | input | 32 | Virtual address |
| instr_i | input | 1 | 1 = instruction fetch, 0 = data access |
| priv_i | input | 1 | Privileged mode |
| single_virt_i | input | 1 | Single virtual space control |
| pte_hi_i | input | 32 | Page number [31:10], current/load tag [7:0] |
| pte_lo_i | input | 32 | Physical page [28:10], valid [8], shared [1] |
| load_i | input | 1 | Load command into the unified table |
| resp_valid_o | output | 1 | Lookup result valid |
| hit_o | output | 1 | Translation hit |
| ppn_o | output | 19 | Physical page number on hit |
| itlb_miss_o | output | 1 | Instruction miss |
| dtlb_miss_o | output | 1 | Data miss |
| multi_hit_o | output | 1 | Multiple-hit error |

## Verification
The bench covers the tag-enable rule with each of the four combinations of privileged and single-space bits. A design that used AND instead of OR would hit in the mixed cases. It loads a shared entry under a foreign tag, so a design that still honoured the shared bit would hit. The bench also creates duplicate unified entries and checks two things: that data lookups flag multiple hits, and that instruction fetches keep hitting their stored copy until four later refills evict it, which shows both the table order and the round-robin order. Sixty-four loads wrap the replacement counter. A counter that saturated, or that started from another slot, would leave the duplicate in place.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  parameter int VA_W     = 32;
  parameter int PA_W     = 29;
  parameter int PG_SHIFT = 10;
  parameter int ASID_W   = 8;
  localparam int VPN_W   = VA_W - PG_SHIFT;
  localparam int PPN_W   = PA_W - PG_SHIFT;
  localparam int LO_V_BIT  = 8;
  localparam int LO_SH_BIT = 1;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
#(
  parameter int N = 4
) (
  input  tlb_entry_t [N-1:0]  entries_i,
  input  logic [VPN_W-1:0]    vpn_i,
  input  logic [ASID_W-1:0]   asid_i,
  input  logic                use_asid_i,
  output logic                hit_o,
  output logic                multi_o,
  output tlb_entry_t          entry_o
);
  localparam int CNT_W = $clog2(N + 1);

  logic [N-1:0] match;
  logic [CNT_W-1:0] cnt;

  // shared bit deliberately not consulted
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = entries_i[g].valid
                    && (entries_i[g].vpn == vpn_i)
                    && (!use_asid_i || (entries_i[g].asid == asid_i));
  end

  always_comb begin
    cnt     = '0;
    entry_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i]) begin
        cnt     = cnt + CNT_W'(1);
        entry_o = entries_i[i];
      end
    end
  end

  assign hit_o   = |match;
  assign multi_o = (cnt > CNT_W'(1));
endmodule

// File: rtl/tlb_utlb_store.sv
module tlb_utlb_store
  import tlb_pkg::*;
#(
  parameter int N = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [31:0]        pte_hi_i,
  input  logic [31:0]        pte_lo_i,
  output tlb_entry_t [N-1:0] entries_o
);
  localparam int IDX_W = $clog2(N);

  logic [IDX_W-1:0] urc_q;
  tlb_entry_t       new_entry;

  assign new_entry.valid  = pte_lo_i[LO_V_BIT];
  assign new_entry.shared = pte_lo_i[LO_SH_BIT];
  assign new_entry.asid   = pte_hi_i[ASID_W-1:0];
  assign new_entry.vpn    = pte_hi_i[VA_W-1:PG_SHIFT];
  assign new_entry.ppn    = pte_lo_i[PA_W-1:PG_SHIFT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      urc_q     <= '0;
      entries_o <= '0;
    end else if (load_i) begin
      entries_o[urc_q] <= new_entry;
      urc_q            <= urc_q + IDX_W'(1);  // wraps modulo N
    end
  end

  // R7: load lands in the slot the counter pointed at
  a_r7_load_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (entries_o[$past(urc_q)].vpn == $past(pte_hi_i[VA_W-1:PG_SHIFT]))
            && (entries_o[$past(urc_q)].ppn == $past(pte_lo_i[PA_W-1:PG_SHIFT])));

  a_r7_urc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(urc_q));
endmodule

// File: rtl/tlb_itlb_store.sv
module tlb_itlb_store
  import tlb_pkg::*;
#(
  parameter int N = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               refill_i,
  input  tlb_entry_t         refill_entry_i,
  output tlb_entry_t [N-1:0] entries_o
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [IDX_W-1:0] rr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q      <= '0;
      entries_o <= '0;
    end else if (refill_i) begin
      entries_o[rr_q] <= refill_entry_i;
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + IDX_W'(1);
    end
  end

  // R12: refill written at round-robin slot, pointer then moves on
  a_r12_refill_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refill_i |=> entries_o[$past(rr_q)] == $past(refill_entry_i));

  a_r12_rr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !refill_i |=> $stable(rr_q));
endmodule

// File: rtl/tlb_two_level.sv
module tlb_two_level
  import tlb_pkg::*;
#(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             instr_i,
  input  logic             priv_i,
  input  logic             single_virt_i,
  input  logic [31:0]      pte_hi_i,
  input  logic [31:0]      pte_lo_i,
  input  logic             load_i,
  output logic             resp_valid_o,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             itlb_miss_o,
  output logic             dtlb_miss_o,
  output logic             multi_hit_o
);
  tlb_entry_t [ITLB_N-1:0] itlb;
  tlb_entry_t [UTLB_N-1:0] utlb;
  tlb_entry_t i_entry, u_entry;
  logic i_hit, i_multi, u_hit, u_multi;
  logic use_asid, refill;
  logic [VPN_W-1:0]  vpn;
  logic [ASID_W-1:0] cur_asid;

  logic             n_hit, n_imiss, n_dmiss, n_multi;
  logic [PPN_W-1:0] n_ppn;

  assign vpn      = va_i[VA_W-1:PG_SHIFT];
  assign cur_asid = pte_hi_i[ASID_W-1:0];
  assign use_asid = !single_virt_i || !priv_i;

  tlb_match #(.N(ITLB_N)) u_imatch (
    .entries_i(itlb), .vpn_i(vpn), .asid_i(cur_asid), .use_asid_i(use_asid),
    .hit_o(i_hit), .multi_o(i_multi), .entry_o(i_entry)
  );

  tlb_match #(.N(UTLB_N)) u_umatch (
    .entries_i(utlb), .vpn_i(vpn), .asid_i(cur_asid), .use_asid_i(use_asid),
    .hit_o(u_hit), .multi_o(u_multi), .entry_o(u_entry)
  );

  tlb_utlb_store #(.N(UTLB_N)) u_ustore (
    .clk_i, .rst_ni, .load_i, .pte_hi_i, .pte_lo_i, .entries_o(utlb)
  );

  tlb_itlb_store #(.N(ITLB_N)) u_istore (
    .clk_i, .rst_ni, .refill_i(refill), .refill_entry_i(u_entry), .entries_o(itlb)
  );

  always_comb begin
    n_hit = 1'b0; n_imiss = 1'b0; n_dmiss = 1'b0; n_multi = 1'b0;
    n_ppn = '0;   refill = 1'b0;
    if (req_i) begin
      if (instr_i) begin
        if (i_multi)      n_multi = 1'b1;
        else if (i_hit) begin
          n_hit = 1'b1; n_ppn = i_entry.ppn;
        end
        else if (u_multi) n_multi = 1'b1;
        else if (u_hit) begin
          n_hit = 1'b1; n_ppn = u_entry.ppn; refill = 1'b1;
        end
        else              n_imiss = 1'b1;
      end else begin
        if (u_multi)      n_multi = 1'b1;
        else if (u_hit) begin
          n_hit = 1'b1; n_ppn = u_entry.ppn;
        end
        else              n_dmiss = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      ppn_o        <= '0;
      itlb_miss_o  <= 1'b0;
      dtlb_miss_o  <= 1'b0;
      multi_hit_o  <= 1'b0;
    end else begin
      resp_valid_o <= req_i;
      hit_o        <= n_hit;
      ppn_o        <= n_ppn;
      itlb_miss_o  <= n_imiss;
      dtlb_miss_o  <= n_dmiss;
      multi_hit_o  <= n_multi;
    end
  end

  // R2: one outcome per response, none otherwise
  a_r2_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> $countones({hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o}) == 1);
  a_r2_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !(hit_o || itlb_miss_o || dtlb_miss_o || multi_hit_o));
  a_r2_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> resp_valid_o);
  // R10: instruction misses never show up as data misses
  a_r10_imiss_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && instr_i |=> !dtlb_miss_o);
  // R8: data lookups never report instruction misses nor refill
  a_r8_dmiss_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !instr_i |=> !itlb_miss_o);
  a_r8_no_data_refill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !instr_i |-> !refill);
  // R11: multiple hit excludes hit
  a_r11_multi_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    multi_hit_o |-> !hit_o);
endmodule

// File: tb/tlb_two_level_bench.sv
module tlb_two_level_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [31:0] va_i = '0;
  logic        instr_i = 1'b0;
  logic        priv_i = 1'b0;
  logic        single_virt_i = 1'b0;
  logic [31:0] pte_hi_i = '0;
  logic [31:0] pte_lo_i = '0;
  logic        load_i = 1'b0;
  logic        resp_valid_o, hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o;
  logic [18:0] ppn_o;

  int n_tests = 0;
  int n_fail  = 0;
  int loads   = 0;

  localparam logic [3:0] O_HIT = 4'b1000, O_IMISS = 4'b0100,
                         O_DMISS = 4'b0010, O_MULTI = 4'b0001;

  always #2 clk_i = ~clk_i;

  tlb_two_level u_tlb_two_level (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [21:0] vpn, input logic [7:0] asid,
                      input logic [18:0] ppn, input bit v, input bit sh);
    @(negedge clk_i);
    pte_hi_i = {vpn, 2'b00, asid};
    pte_lo_i = {3'b000, ppn, 1'b0, v, 6'b0, sh, 1'b0};
    load_i   = 1'b1;
    @(negedge clk_i);
    load_i   = 1'b0;
    loads++;
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input bit instr,
                        input logic [7:0] asid, input bit priv, input bit sv,
                        input logic [3:0] exp_o, input logic [18:0] exp_ppn);
    @(negedge clk_i);
    va_i = va; instr_i = instr; priv_i = priv; single_virt_i = sv;
    pte_hi_i = {24'h0, asid};
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    check(resp_valid_o == 1'b1, {tag, " R2 valid"}, resp_valid_o, 1);
    check({hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o} == exp_o, tag,
          {hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o}, exp_o);
    if (exp_o == O_HIT) check(ppn_o == exp_ppn, {tag, " ppn"}, ppn_o, exp_ppn);
    @(negedge clk_i);
    check(resp_valid_o == 1'b0 && {hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o} == 4'b0,
          {tag, " R2 idle"}, {resp_valid_o, hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o}, 0);
  endtask

  task automatic t_reset;
    check({resp_valid_o, hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o} == 5'b0,
          "R1 reset outputs", {resp_valid_o, hit_o, itlb_miss_o, dtlb_miss_o, multi_hit_o}, 0);
    lookup("R1 R8 data after reset", 32'h0, 1'b0, 8'd0, 1'b0, 1'b0, O_DMISS, 0);
    lookup("R1 R10 instr after reset", 32'h0, 1'b1, 8'd0, 1'b0, 1'b0, O_IMISS, 0);
  endtask

  task automatic t_invalid;
    load(22'h100, 8'd5, 19'h7, 1'b0, 1'b0);  // slot 0
    lookup("R3 invalid entry", {22'h100, 10'h0}, 1'b0, 8'd5, 1'b1, 1'b1, O_DMISS, 0);
  endtask

  task automatic t_asid;
    load(22'h200, 8'd5, 19'h11, 1'b1, 1'b1); // slot 1, shared
    lookup("R7 load then hit", {22'h200, 10'h0}, 1'b0, 8'd5, 1'b0, 1'b0, O_HIT, 19'h11);
    lookup("R4 R5 sv0 priv0 foreign tag", {22'h200, 10'h0}, 1'b0, 8'd6, 1'b0, 1'b0, O_DMISS, 0);
    lookup("R4 sv1 priv0 foreign tag", {22'h200, 10'h0}, 1'b0, 8'd6, 1'b0, 1'b1, O_DMISS, 0);
    lookup("R4 sv0 priv1 foreign tag", {22'h200, 10'h0}, 1'b0, 8'd6, 1'b1, 1'b0, O_DMISS, 0);
    lookup("R4 sv1 priv1 tag ignored", {22'h200, 10'h0}, 1'b0, 8'd6, 1'b1, 1'b1, O_HIT, 19'h11);
    lookup("R6 offset ignored", {22'h200, 10'h3ff}, 1'b0, 8'd5, 1'b0, 1'b0, O_HIT, 19'h11);
    lookup("R6 bit10 compared", {22'h201, 10'h0}, 1'b0, 8'd5, 1'b0, 1'b0, O_DMISS, 0);
  endtask

  task automatic t_refill;
    lookup("R9 instr refill hit", {22'h200, 10'h4}, 1'b1, 8'd5, 1'b0, 1'b0, O_HIT, 19'h11);
    load(22'h200, 8'd5, 19'h22, 1'b1, 1'b0); // slot 2, duplicate page
    lookup("R11 data duplicate", {22'h200, 10'h0}, 1'b0, 8'd5, 1'b0, 1'b0, O_MULTI, 0);
    lookup("R9 instr served by copy", {22'h200, 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0, O_HIT, 19'h11);
  endtask

  task automatic t_round_robin;
    for (int k = 0; k < 3; k++) begin
      load(22'h300 + 22'(k), 8'd5, 19'h40 + 19'(k), 1'b1, 1'b0);
      lookup("R12 fill", {22'h300 + 22'(k), 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0,
             O_HIT, 19'h40 + 19'(k));
    end
    lookup("R12 copy kept after three refills", {22'h200, 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0,
           O_HIT, 19'h11);
    load(22'h303, 8'd5, 19'h43, 1'b1, 1'b0);
    lookup("R12 fourth refill", {22'h303, 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0, O_HIT, 19'h43);
    lookup("R12 R11 copy evicted", {22'h200, 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0, O_MULTI, 0);
    lookup("R10 instr double miss", {22'h3ff, 10'h0}, 1'b1, 8'd5, 1'b0, 1'b0, O_IMISS, 0);
  endtask

  task automatic t_wrap;
    // refill counter until it points at slot 1 again (first valid duplicate)
    while (loads % 64 != 1) load(22'h1000 + 22'(loads), 8'd9, 19'h0, 1'b1, 1'b0);
    load(22'h500, 8'd5, 19'h55, 1'b1, 1'b0);
    lookup("R7 wrap replaced slot", {22'h200, 10'h0}, 1'b0, 8'd5, 1'b0, 1'b0, O_HIT, 19'h22);
    lookup("R7 wrap new entry", {22'h500, 10'h0}, 1'b0, 8'd5, 1'b0, 1'b0, O_HIT, 19'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_invalid();
    t_asid();
    t_refill();
    t_round_robin();
    t_wrap();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule